// File: doc/BRIEF.md
# Mode-Aware Paired-Cell Wordline Controller

This block is the row control for an SRAM array whose cells can be linked in pairs. Each memory block holds its own run-time storage mode. In normal mode every cell holds one bit. In fast mode and in robust mode one bit is held across two linked cells. The controller keeps the per-block modes and drives one active-low pair-link control per block. It takes a request through a valid/ready handshake and decodes the address into a block, a row (or row pair) and a column block. It then pulses the wordlines for one cycle.

Each row has two wordline nets, A and B. Column blocks of even index hold pairs aligned to even rows, and these are reached on the B nets. Column blocks of odd index hold pairs shifted down by one row, and these are reached on the A nets. A paired write therefore only touches the pair that was selected. The controller also reports the usable row count of each block. A linked block offers half the rows of a normal one.

The control is a three-state machine. ST_IDLE accepts a request: it goes to ST_DRIVE when the address is legal and to ST_FAULT when it is not. ST_DRIVE holds the wordlines and the column select for one cycle and then returns to ST_IDLE. ST_FAULT raises the address-error flag for one cycle and then returns to ST_IDLE. A request can be accepted at most every second cycle.

Top module: `paired_wl_ctrl`

## Requirements
- R1: After reset, every wordline and every column-select bit is low, addr_err is low, req_ready is high, every block is in normal mode (link_n all ones), and cap_rows reports 16 rows for every block.
- R2: In a normal-mode block (mode code 0), an access raises exactly one wordline, the one of the addressed row. The B net is used when the column-block index is even and the A net when it is odd. Wordline bit index is block*16+row.
- R3: In a fast-mode block (mode code 1), reads and writes raise both wordlines of the selected pair, and the block's link_n is low.
- R4: In a robust-mode block (mode code 2), a read raises only the first row of the selected pair, and the block's link_n is low.
- R5: A write to a robust-mode block raises both wordlines of the pair, exactly as in fast mode.
- R6: In a linked block, logical row k in an even column block selects rows 2k and 2k+1 on the B nets. In an odd column block it selects rows 2k+1 and 2k+2 on the A nets, and the top pair wraps to rows 15 and 0. A and B nets are never high in the same cycle.
- R7: In a linked block, a logical row of 8 or more raises addr_err for exactly one cycle and raises no wordline and no column select.
- R8: mode_wdata holds two bits per block, with block b in bits [2b+1:2b]. A load is taken only while the controller is idle and req_valid is low, and it takes effect from the next cycle. At any other time mode_we is ignored. Code 3 is stored as normal.
- R9: cap_rows holds five bits per block, with block b in bits [5b+4:5b]. It shows 16 for a normal block and 8 for a linked block.
- R10: The wordlines and the one-hot column select come up in the cycle after the accepting clock edge and stay for exactly one cycle. During that cycle req_ready is low. No more than two wordlines are ever high at once.
- R11: Each block's mode, link control and capacity are independent of the other blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | Request is a write |
| req_addr | input | 9 | {block[1:0], row[3:0], column block[2:0]} |
| mode_we | input | 1 | Load per-block modes |
| mode_wdata | input | 8 | Two-bit mode code per block |
| wl_a | output | 64 | A-net wordlines, bit block*16+row |
| wl_b | output | 64 | B-net wordlines, bit block*16+row |
| col_sel | output | 8 | One-hot column-block select |
| link_n | output | 4 | Active-low pair-link control per block |
| addr_err | output | 1 | Out-of-range linked access |
| cap_rows | output | 20 | Usable row count per block |

## Verification
A mode load and an access request can arrive in the same idle cycle. The bench drives both together and checks two things: the access is decoded with the old modes, and link_n and cap_rows keep their old values afterwards. A second test raises mode_we in the cycle where the wordlines are high. The bench checks that the load is again ignored, both at the link and capacity outputs and in the decode of the next access.

// File: rtl/sram_pair_pkg.sv
package sram_pair_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_FAST   = 2'b01,
        MODE_SAFE   = 2'b10
    } cell_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DRIVE,
        ST_FAULT
    } ctl_state_e;

endpackage

// File: rtl/pair_mode_regs.sv
module pair_mode_regs
    import sram_pair_pkg::*;
#(
    parameter int NB   = 4,
    parameter int ROWS = 16,
    localparam int CW  = $clog2(ROWS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [2*NB-1:0]   wdata,
    output logic [2*NB-1:0]   modes,
    output logic [NB-1:0]     link_n,
    output logic [NB*CW-1:0]  cap_rows
);

    localparam logic [CW-1:0] FULL_ROWS = CW'(ROWS);
    localparam logic [CW-1:0] HALF_ROWS = CW'(ROWS / 2);

    for (genvar b = 0; b < NB; b++) begin : g_blk
        logic [1:0] mode_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mode_q <= MODE_NORMAL;
            end else if (load_en) begin
                mode_q <= (wdata[2*b +: 2] == 2'b11) ? MODE_NORMAL : wdata[2*b +: 2];
            end
        end

        assign modes[2*b +: 2]     = mode_q;
        assign link_n[b]           = (mode_q == MODE_NORMAL);
        assign cap_rows[CW*b +: CW] = (mode_q == MODE_NORMAL) ? FULL_ROWS : HALF_ROWS;
    end

endmodule

// File: rtl/pair_row_decode.sv
module pair_row_decode
    import sram_pair_pkg::*;
#(
    parameter int NB   = 4,
    parameter int ROWS = 16,
    parameter int NCOL = 8,
    localparam int RW  = $clog2(ROWS),
    localparam int BW  = $clog2(NB),
    localparam int CLW = $clog2(NCOL),
    localparam int AW  = BW + RW + CLW,
    localparam int NWL = NB * ROWS
) (
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [2*NB-1:0]  modes,
    output logic [NWL-1:0]   wl_a,
    output logic [NWL-1:0]   wl_b,
    output logic [NCOL-1:0]  col_onehot,
    output logic             err
);

    logic [BW-1:0]  blk;
    logic [RW-1:0]  row;
    logic [CLW-1:0] col;
    logic [1:0]     mbits;
    logic           par;
    logic           paired;
    logic           both;
    logic [RW-1:0]  r0;
    logic [RW-1:0]  r1;

    assign {blk, row, col} = addr;
    assign mbits  = modes[2*blk +: 2];
    assign par    = col[0];
    assign paired = (mbits == MODE_FAST) || (mbits == MODE_SAFE);
    assign both   = (mbits == MODE_FAST) || ((mbits == MODE_SAFE) && we);

    always_comb begin
        wl_a       = '0;
        wl_b       = '0;
        col_onehot = '0;
        err        = 1'b0;
        if (paired) begin
            r0  = {row[RW-2:0], par};
            r1  = r0 + 1'b1;
            err = row[RW-1];
        end else begin
            r0 = row;
            r1 = row;
        end
        if (!err) begin
            col_onehot[col] = 1'b1;
            if (par) begin
                wl_a[{blk, r0}] = 1'b1;
                if (both) wl_a[{blk, r1}] = 1'b1;
            end else begin
                wl_b[{blk, r0}] = 1'b1;
                if (both) wl_b[{blk, r1}] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/paired_wl_ctrl.sv
module paired_wl_ctrl
    import sram_pair_pkg::*;
#(
    parameter int NB   = 4,
    parameter int ROWS = 16,
    parameter int NCOL = 8,
    localparam int RW  = $clog2(ROWS),
    localparam int BW  = $clog2(NB),
    localparam int CLW = $clog2(NCOL),
    localparam int AW  = BW + RW + CLW,
    localparam int NWL = NB * ROWS,
    localparam int CW  = RW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [AW-1:0]     req_addr,
    input  logic              mode_we,
    input  logic [2*NB-1:0]   mode_wdata,
    output logic [NWL-1:0]    wl_a,
    output logic [NWL-1:0]    wl_b,
    output logic [NCOL-1:0]   col_sel,
    output logic [NB-1:0]     link_n,
    output logic              addr_err,
    output logic [NB*CW-1:0]  cap_rows
);

    ctl_state_e state_q, state_d;
    logic [2*NB-1:0] modes;
    logic [NWL-1:0]  dec_a, dec_b;
    logic [NCOL-1:0] dec_col;
    logic            dec_err;
    logic            accept;
    logic            mode_load;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && (state_q == ST_IDLE);
    assign mode_load = mode_we && (state_q == ST_IDLE) && !req_valid;

    pair_mode_regs #(.NB(NB), .ROWS(ROWS)) u_modes (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (mode_load),
        .wdata    (mode_wdata),
        .modes    (modes),
        .link_n   (link_n),
        .cap_rows (cap_rows)
    );

    pair_row_decode #(.NB(NB), .ROWS(ROWS), .NCOL(NCOL)) u_dec (
        .we         (req_we),
        .addr       (req_addr),
        .modes      (modes),
        .wl_a       (dec_a),
        .wl_b       (dec_b),
        .col_onehot (dec_col),
        .err        (dec_err)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = dec_err ? ST_FAULT : ST_DRIVE;
            ST_DRIVE: state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wl_a     <= '0;
            wl_b     <= '0;
            col_sel  <= '0;
            addr_err <= 1'b0;
        end else if (accept && !dec_err) begin
            wl_a     <= dec_a;
            wl_b     <= dec_b;
            col_sel  <= dec_col;
            addr_err <= 1'b0;
        end else begin
            wl_a     <= '0;
            wl_b     <= '0;
            col_sel  <= '0;
            addr_err <= accept && dec_err;
        end
    end

    AST_WL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wl_a, wl_b}) <= 2); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> ((wl_a == '0) && (wl_b == '0) && !addr_err)); // R10
    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((wl_a != '0) || (wl_b != '0)) |=> ((wl_a == '0) && (wl_b == '0))); // R10
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> ((wl_a == '0) && (wl_b == '0) && (col_sel == '0))); // R7
    AST_NET_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        !((wl_a != '0) && (wl_b != '0))); // R6
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(link_n)); // R8
    AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_sel)); // R10

endmodule

// File: tb/paired_wl_ctrl_tb.sv
module paired_wl_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [8:0]  req_addr = '0;
    logic        mode_we = 1'b0;
    logic [7:0]  mode_wdata = '0;
    logic [63:0] wl_a, wl_b;
    logic [7:0]  col_sel;
    logic [3:0]  link_n;
    logic        addr_err;
    logic [19:0] cap_rows;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;
    int bmode[4];

    typedef struct {
        logic        err;
        logic [63:0] a;
        logic [63:0] b;
        logic [7:0]  cs;
        string       tag;
    } item_t;

    item_t exp_q[$];

    always #2.5 clk = ~clk;

    paired_wl_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .wl_a(wl_a), .wl_b(wl_b), .col_sel(col_sel), .link_n(link_n),
        .addr_err(addr_err), .cap_rows(cap_rows)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [199:0] act, input logic [199:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic item_t model(input bit we, input int blk, input int row,
                                    input int col, input string tag);
        item_t it;
        int m, par, r0, r1, n;
        it.err = 1'b0; it.a = '0; it.b = '0; it.cs = '0; it.tag = tag;
        m = bmode[blk];
        par = col % 2;
        if (m != 0 && row >= 8) begin
            it.err = 1'b1;
        end else begin
            if (m == 0) begin r0 = row; r1 = row; n = 1; end
            else begin
                r0 = 2 * row + par;
                r1 = (r0 + 1) % 16;
                n = (m == 1 || we) ? 2 : 1;
            end
            if (par == 1) begin
                it.a[blk*16 + r0] = 1'b1;
                if (n == 2) it.a[blk*16 + r1] = 1'b1;
            end else begin
                it.b[blk*16 + r0] = 1'b1;
                if (n == 2) it.b[blk*16 + r1] = 1'b1;
            end
            it.cs[col] = 1'b1;
        end
        return it;
    endfunction

    task automatic access(input bit we, input int blk, input int row, input int col,
                          input string tag, input bit mw_same, input bit mw_busy,
                          input logic [7:0] md);
        exp_q.push_back(model(we, blk, row, col, tag));
        @(negedge clk);
        req_valid  = 1'b1;
        req_we     = we;
        req_addr   = {blk[1:0], row[3:0], col[2:0]};
        mode_we    = mw_same;
        mode_wdata = md;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        mode_we   = mw_busy;
        check(req_ready == 1'b0, "R10", "ready during pulse", 200'(req_ready), 200'(0));
        @(negedge clk);
        mode_we = 1'b0;
        check(req_ready == 1'b1, "R10", "ready after pulse", 200'(req_ready), 200'(1));
    endtask

    task automatic load_modes(input logic [7:0] md);
        @(negedge clk);
        mode_we = 1'b1;
        mode_wdata = md;
        @(negedge clk);
        mode_we = 1'b0;
        for (int b = 0; b < 4; b++) begin
            bmode[b] = (md[2*b +: 2] == 2'b11) ? 0 : int'(md[2*b +: 2]);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && ((wl_a != '0) || (wl_b != '0) || addr_err)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected output", {addr_err, wl_a, wl_b}, 200'(0));
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check({addr_err, wl_a, wl_b, col_sel} == {e.err, e.a, e.b, e.cs}, e.tag,
                      "err/wl_a/wl_b/col_sel",
                      {addr_err, wl_a, wl_b, col_sel}, {e.err, e.a, e.b, e.cs});
            end
        end
    end

    initial begin
        for (int b = 0; b < 4; b++) bmode[b] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(wl_a == '0 && wl_b == '0, "R1", "wordlines", {wl_a, wl_b}, 200'(0));
        check(col_sel == '0 && !addr_err, "R1", "col/err", {col_sel, addr_err}, 200'(0));
        check(req_ready == 1'b1, "R1", "ready", 200'(req_ready), 200'(1));
        check(link_n == 4'hF, "R1", "link_n", 200'(link_n), 200'(4'hF));
        check(cap_rows == {4{5'd16}}, "R1", "cap_rows", 200'(cap_rows), 200'({4{5'd16}}));

        access(1'b0, 0, 5, 2, "R2", 1'b0, 1'b0, 8'h00);
        access(1'b1, 0, 6, 3, "R2", 1'b0, 1'b0, 8'h00);
        access(1'b0, 0, 15, 0, "R2", 1'b0, 1'b0, 8'h00);

        load_modes(8'b11_10_01_00);
        check(link_n == 4'b1001, "R11", "link_n per block", 200'(link_n), 200'(4'b1001));
        check(cap_rows == {5'd16, 5'd8, 5'd8, 5'd16}, "R9", "cap_rows",
              200'(cap_rows), 200'({5'd16, 5'd8, 5'd8, 5'd16}));

        access(1'b0, 1, 2, 0, "R3", 1'b0, 1'b0, 8'h00);
        access(1'b1, 1, 2, 4, "R3", 1'b0, 1'b0, 8'h00);
        access(1'b0, 2, 3, 0, "R4", 1'b0, 1'b0, 8'h00);
        access(1'b0, 2, 1, 1, "R4", 1'b0, 1'b0, 8'h00);
        access(1'b1, 2, 3, 0, "R5", 1'b0, 1'b0, 8'h00);
        access(1'b1, 2, 4, 7, "R5", 1'b0, 1'b0, 8'h00);
        access(1'b0, 1, 3, 1, "R6", 1'b0, 1'b0, 8'h00);
        access(1'b0, 1, 7, 5, "R6", 1'b0, 1'b0, 8'h00);
        access(1'b0, 1, 9, 2, "R7", 1'b0, 1'b0, 8'h00);
        access(1'b1, 2, 15, 3, "R7", 1'b0, 1'b0, 8'h00);
        access(1'b0, 3, 12, 6, "R11", 1'b0, 1'b0, 8'h00);

        access(1'b0, 0, 1, 0, "R8", 1'b1, 1'b0, 8'h55);
        check(link_n == 4'b1001, "R8", "load with request ignored", 200'(link_n), 200'(4'b1001));
        access(1'b0, 1, 1, 0, "R8", 1'b0, 1'b1, 8'h00);
        check(link_n == 4'b1001, "R8", "load while busy ignored", 200'(link_n), 200'(4'b1001));
        check(cap_rows == {5'd16, 5'd8, 5'd8, 5'd16}, "R8", "cap after ignored load",
              200'(cap_rows), 200'({5'd16, 5'd8, 5'd8, 5'd16}));
        access(1'b0, 1, 1, 2, "R8", 1'b0, 1'b0, 8'h00);

        load_modes(8'b00_00_00_01);
        check(link_n == 4'b1110, "R8", "idle load applied", 200'(link_n), 200'(4'b1110));
        access(1'b0, 0, 4, 1, "R3", 1'b0, 1'b0, 8'h00);
        access(1'b0, 2, 9, 1, "R2", 1'b0, 1'b0, 8'h00);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10", "pending results", 200'(exp_q.size()), 200'(0));
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL R10 watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule